// File: doc/BRIEF.md
# Busy Status Polling Responder

This block sits on the read-data path of a nonvolatile memory that runs internal program cycles. It chooses what the read bus carries. While the memory is idle, the bus carries the array data. While a program cycle runs, the bus carries a status word instead. The status word holds two end-of-cycle indicators, and software can watch either one.

The first indicator is an inverted copy of the most significant bit of the byte loaded last. It stays inverted until the cycle finishes, and then the true bit comes back. The second indicator is a bit that changes value on every new read access while the cycle runs.

A read access is the time during which chip enable and output enable are both active. Dropping either enable, or both, and raising it again starts a new access. Software may start polling at any point in the cycle.

The busy input comes from the program controller. That controller also raises it for the full cycle time when protection rejects a write, so a rejected write produces the same polling behaviour as a real one. The busy input is registered once inside the block. The mux therefore switches one clock after busy changes, and any read made a clock or more after busy falls returns true data.

Top module: `poll_status_responder`

## Requirements
- R1: After reset, with no read active, the bus is all zeros. The first new read access made while busy after reset shows bit 6 = 1.
- R2: When the registered busy state is low and a read is active, the bus equals the array data on all eight bits.
- R3: When the registered busy state is high and a read is active, bit 7 of the bus is the complement of the last-loaded MSB input.
- R4: When the registered busy state is high and a read is active, bits 5 to 0 of the bus are 0.
- R5: While busy, bit 6 holds one value for the whole of a read access. Each new read access shows the opposite value to the previous busy access.
- R6: A new access is recognised the same way in three cases: chip enable is dropped and raised, output enable is dropped and raised, or both are dropped and raised.
- R7: The busy input is sampled on the clock. A change of busy_i is first seen on the bus after the next rising clock edge, and not before it.
- R8: When chip enable or output enable is inactive, the bus is all zeros.
- R9: The toggle state does not advance on accesses made while idle. The first busy access after an idle period shows the opposite bit 6 to the last busy access before that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Program cycle (or rejected-write timer) in progress |
| last_msb_i | input | 1 | Bit 7 of the most recently loaded byte |
| array_data_i | input | 8 | Data read from the memory array |
| chip_en_i | input | 1 | Chip enable, active high |
| out_en_i | input | 1 | Output enable, active high |
| rd_data_o | output | 8 | Read bus |

## Verification
A toggle register that misses an edge, or flips one time too many, shows on bit 6. The next busy access repeats the value of the one before instead of alternating, and the bench checks this on every access. A stale busy register shows within one clock: the bus returns a status word where array data is expected, or the other way round, on the first sample after the edge. A wrong access-edge register shows in one of two ways. Bit 6 changes during a single access, or a chip-enable-only access fails to advance the toggle. The bench sweeps all byte values to expose any miswired bit position.

// File: rtl/poll_resp_pkg.sv
package poll_resp_pkg;
  typedef enum logic [1:0] {
    MUX_QUIET  = 2'd0,
    MUX_ARRAY  = 2'd1,
    MUX_STATUS = 2'd2
  } mux_sel_e;
endpackage

// File: rtl/poll_access_detect.sv
module poll_access_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en_i,
  input  logic out_en_i,
  output logic active_o,
  output logic start_o
);
  logic active_q;
  logic active_d;

  always_comb begin
    active_d = chip_en_i & out_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else begin
      active_q <= active_d;
    end
  end

  assign active_o = active_d;
  assign start_o  = active_d & ~active_q;
endmodule

// File: rtl/poll_toggle_bit.sv
module poll_toggle_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic start_i,
  output logic shown_o
);
  logic tog_q;
  logic tog_d;
  logic adv_en;

  always_comb begin
    adv_en = busy_i & start_i;
    tog_d  = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (adv_en) begin
      tog_q <= tog_d;
    end
  end

  // the value shown during an access is the advanced one from its first cycle
  assign shown_o = tog_q ^ adv_en;
endmodule

// File: rtl/poll_read_mux.sv
module poll_read_mux
  import poll_resp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = DATA_W - 1,
  parameter int TOG_BIT  = DATA_W - 2
) (
  input  mux_sel_e          sel_i,
  input  logic              last_msb_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] status_word;

  for (genvar b = 0; b < DATA_W; b++) begin : g_status
    if (b == FLAG_BIT) begin : g_flag
      assign status_word[b] = ~last_msb_i;
    end else if (b == TOG_BIT) begin : g_tog
      assign status_word[b] = tog_i;
    end else begin : g_zero
      assign status_word[b] = 1'b0;
    end
  end

  always_comb begin
    case (sel_i)
      MUX_ARRAY:  rd_data_o = array_data_i;
      MUX_STATUS: rd_data_o = status_word;
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/poll_status_responder.sv
module poll_status_responder
  import poll_resp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TOG_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              last_msb_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              chip_en_i,
  input  logic              out_en_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int FLAG_BIT = DATA_W - 1;

  logic     busy_q;
  logic     busy_d;
  logic     rd_active;
  logic     rd_start;
  logic     tog_shown;
  mux_sel_e sel;

  always_comb begin
    busy_d = busy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  poll_access_detect u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en_i (chip_en_i),
    .out_en_i  (out_en_i),
    .active_o  (rd_active),
    .start_o   (rd_start)
  );

  poll_toggle_bit u_toggle (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_i  (busy_q),
    .start_i (rd_start),
    .shown_o (tog_shown)
  );

  always_comb begin
    if (!rd_active)  sel = MUX_QUIET;
    else if (busy_q) sel = MUX_STATUS;
    else             sel = MUX_ARRAY;
  end

  poll_read_mux #(
    .DATA_W   (DATA_W),
    .FLAG_BIT (FLAG_BIT),
    .TOG_BIT  (TOG_BIT)
  ) u_mux (
    .sel_i        (sel),
    .last_msb_i   (last_msb_i),
    .tog_i        (tog_shown),
    .array_data_i (array_data_i),
    .rd_data_o    (rd_data_o)
  );
endmodule

// File: rtl/poll_resp_chk.sv
module poll_resp_chk #(
  parameter int DATA_W  = 8,
  parameter int TOG_BIT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_i,
  input logic              last_msb_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic              chip_en_i,
  input logic              out_en_i,
  input logic [DATA_W-1:0] rd_data_o
);
  // R8
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_en_i && out_en_i) |-> (rd_data_o == '0));

  // R2
  idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en_i && out_en_i && !$past(busy_i)) |-> (rd_data_o == array_data_i));

  // R3
  poll_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en_i && out_en_i && $past(busy_i)) |-> (rd_data_o[DATA_W-1] == !last_msb_i));

  // R4
  status_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en_i && out_en_i && $past(busy_i)) |-> (rd_data_o[TOG_BIT-1:0] == '0));

  // R5
  tog_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en_i && out_en_i && $past(chip_en_i && out_en_i) && $past(busy_i) && $past(busy_i, 2))
      |-> $stable(rd_data_o[TOG_BIT]));
endmodule

bind poll_status_responder poll_resp_chk #(
  .DATA_W  (DATA_W),
  .TOG_BIT (TOG_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_i       (busy_i),
  .last_msb_i   (last_msb_i),
  .array_data_i (array_data_i),
  .chip_en_i    (chip_en_i),
  .out_en_i     (out_en_i),
  .rd_data_o    (rd_data_o)
);

// File: tb/poll_status_responder_tb.sv
module poll_status_responder_tb;
  logic       clk;
  logic       rst_n;
  logic       busy_i;
  logic       last_msb_i;
  logic [7:0] array_data_i;
  logic       chip_en_i;
  logic       out_en_i;
  logic [7:0] rd_data_o;

  int n_run;
  int n_fail;
  logic prev_b6;
  logic have_prev;

  poll_status_responder u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_i),
    .last_msb_i   (last_msb_i),
    .array_data_i (array_data_i),
    .chip_en_i    (chip_en_i),
    .out_en_i     (out_en_i),
    .rd_data_o    (rd_data_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // end the current access in one of three ways, then open a new one; samples after the open
  task automatic new_access(input int mode);
    @(negedge clk);
    if (mode == 0)      out_en_i  = 1'b0;
    else if (mode == 1) chip_en_i = 1'b0;
    else begin
      out_en_i  = 1'b0;
      chip_en_i = 1'b0;
    end
    #1 check("R8", rd_data_o, 8'h00);
    @(posedge clk);
    @(negedge clk);
    chip_en_i = 1'b1;
    out_en_i  = 1'b1;
    #1;
  endtask

  task automatic busy_access(input int mode, input logic msb, input string req);
    logic [7:0] exp;
    logic       b6;
    last_msb_i = msb;
    new_access(mode);
    b6  = have_prev ? ~prev_b6 : 1'b1;
    exp = {~msb, b6, 6'b0};
    check(req, rd_data_o, exp);
    @(posedge clk);
    #1 check("R5", rd_data_o, exp);
    prev_b6   = b6;
    have_prev = 1'b1;
  endtask

  initial begin
    n_run = 0;
    n_fail = 0;
    have_prev = 1'b0;
    prev_b6 = 1'b0;
    rst_n = 1'b0;
    busy_i = 1'b0;
    last_msb_i = 1'b0;
    array_data_i = 8'h00;
    chip_en_i = 1'b0;
    out_en_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1", rd_data_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R1", rd_data_o, 8'h00);

    // idle sweep: every array byte passes through unchanged
    chip_en_i = 1'b1;
    out_en_i  = 1'b1;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      array_data_i = v[7:0];
      #1 check("R2", rd_data_o, v[7:0]);
    end

    // raise busy: not visible before the next rising clock edge
    @(negedge clk);
    busy_i = 1'b1;
    #1 check("R7", rd_data_o, array_data_i);
    @(posedge clk);
    #1 check("R7", rd_data_o, {~last_msb_i, rd_data_o[6], 6'b0});

    // busy sweep with all three ways of starting an access; the first one checks the reset toggle value
    for (int i = 0; i < 256; i++) begin
      array_data_i = 8'(i * 37 + 5);
      busy_access(i % 3, i[0] ^ i[3], (i % 3 == 1) ? "R6" : (i == 0 ? "R1" : "R3"));
    end

    // drop busy mid-access: status until the edge, then true data
    @(negedge clk);
    busy_i = 1'b0;
    array_data_i = 8'h5A;
    #1 check("R7", rd_data_o, {~last_msb_i, prev_b6, 6'b0});
    @(posedge clk);
    #1 check("R7", rd_data_o, 8'h5A);

    // idle accesses must not advance the toggle
    for (int k = 0; k < 5; k++) begin
      array_data_i = 8'(8'hC3 + k);
      new_access(k % 3);
      check("R2", rd_data_o, 8'(8'hC3 + k));
    end

    @(negedge clk);
    busy_i = 1'b1;
    @(posedge clk);
    busy_access(2, 1'b1, "R9");
    busy_access(1, 1'b0, "R4");
    busy_access(0, 1'b1, "R5");

    @(negedge clk);
    chip_en_i = 1'b0;
    #1 check("R8", rd_data_o, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule